// File: doc/BRIEF.md
# Multiplexed-Address Peripheral Window Decoder

This block sits between an 8-bit multiplexed address bus and a small peripheral placed in the top sixteen bytes of a 16-bit memory space. The bus presents the upper address byte while an address strobe is high, then replaces it with the lower byte. The decoder keeps the upper byte in a register and combines it with the lower byte to produce one chip-select, two raw register-select bits, a 2-bit register index and a read-qualified chip-select.

The peripheral has three register groups. Each group answers on four consecutive addresses. The group bits are taken from low-address bits 3 and 2, not bits 2 and 1. This choice lets a three-byte instruction fetch, which starts at the first address of a group, stay inside that one register. The fourth group, 0xFFFC to 0xFFFF, is left unselected. Decoded outputs are registered. They appear one clock after the lower byte is sampled.

Top module: `mawd_window_dec`

## Requirements
- R1: While reset is held, and for two clock edges after it is released, csel=0, rd_csel=0, reg_idx=0 and rsel=2'b11. The stored upper byte is 0x00.
- R2: On each clock edge where as_strb=1, ad_bus is stored as the upper address byte. On edges where as_strb=0, the stored value is left unchanged.
- R3: After an edge where as_strb=0, csel=1 exactly when {stored upper byte, ad_bus} lies in 0xFFF0..0xFFFB.
- R4: After an edge where as_strb=0, rsel equals ad_bus[3:2] when ad_bus[7:4]=4'hF, and 2'b11 otherwise. This holds whatever the stored upper byte is.
- R5: Addresses 0xFFFC..0xFFFF never assert csel.
- R6: reg_idx equals rsel while csel=1: 0 for 0xFFF0..3 (mask/status), 1 for 0xFFF4..7 (control/polling), 2 for 0xFFF8..B (page). reg_idx is 0 while csel=0.
- R7: The addresses 0xFFF8, 0xFFF9 and 0xFFFA, presented one after another, each give csel=1 and reg_idx=2.
- R8: After an edge where as_strb=1, csel=0, rd_csel=0, reg_idx=0 and rsel=2'b11.
- R9: rd_csel equals csel AND rd_strb, where rd_strb is sampled on the same edge.
- R10: An upper byte other than 0xFF keeps csel=0 for every lower byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ad_bus | input | 8 | Multiplexed address byte |
| as_strb | input | 1 | Address strobe, high while the upper byte is on the bus |
| rd_strb | input | 1 | Read strobe, active high |
| csel | output | 1 | Peripheral chip-select |
| rsel | output | 2 | Raw register-select bits (2'b11 means none) |
| reg_idx | output | 2 | Decoded register index, valid while csel=1 |
| rd_csel | output | 1 | Chip-select qualified by the read strobe |

## Verification
The upper-byte register changes on the edge where the strobe is sampled high. Every decoded output is due on the edge after the lower byte is sampled, so each result trails its stimulus by exactly one clock. The bench drives inputs on the falling edge. On each rising edge its behavioural model computes the expected outputs from the inputs it sees, and the bench compares them with the design at the next falling edge. The model also covers the two edges of reset-release delay, so outputs are checked on every cycle, including the ones right after reset.

// File: rtl/mawd_pkg.sv
package mawd_pkg;

  localparam int unsigned IDX_W = 2;

  typedef struct packed {
    logic             cs;
    logic [IDX_W-1:0] rs;
    logic [IDX_W-1:0] idx;
    logic             rd_cs;
  } dec_out_t;

  localparam dec_out_t DEC_IDLE = '{cs: 1'b0, rs: {IDX_W{1'b1}}, idx: '0, rd_cs: 1'b0};

endpackage

// File: rtl/mawd_rst_sync.sv
module mawd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_i
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_i = sync_q[STAGES-1];

endmodule

// File: rtl/mawd_hi_latch.sv
module mawd_hi_latch #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_i,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] hi_q
);

  logic [BYTE_W-1:0] hi_d;

  always_comb begin
    hi_d = hi_q;
    if (load) hi_d = din;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) hi_q <= '0;
    else        hi_q <= hi_d;
  end

  AST_HI_HELD: assert property (@(posedge clk) disable iff (!rst_i)
    !load |=> $stable(hi_q)); // R2

  AST_HI_LOADED: assert property (@(posedge clk) disable iff (!rst_i)
    load |=> (hi_q == $past(din))); // R2

endmodule

// File: rtl/mawd_lo_decode.sv
module mawd_lo_decode
  import mawd_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned IDX_LSB = 2
) (
  input  logic [BYTE_W-1:0] hi_byte,
  input  logic [BYTE_W-1:0] lo_byte,
  input  logic              rd,
  output dec_out_t          dec
);

  localparam int unsigned NIB_W = BYTE_W / 2;

  logic             page_hit;
  logic             nib_hit;
  logic [IDX_W-1:0] rs_w;
  logic             grp_ok;

  assign page_hit = &hi_byte;
  assign nib_hit  = &lo_byte[BYTE_W-1 -: NIB_W];
  assign rs_w     = nib_hit ? lo_byte[IDX_LSB +: IDX_W] : {IDX_W{1'b1}};
  assign grp_ok   = ~&rs_w;

  always_comb begin
    dec       = DEC_IDLE;
    dec.rs    = rs_w;
    dec.cs    = page_hit & nib_hit & grp_ok;
    dec.idx   = dec.cs ? rs_w : '0;
    dec.rd_cs = dec.cs & rd;
  end

endmodule

// File: rtl/mawd_window_dec.sv
module mawd_window_dec
  import mawd_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned IDX_LSB     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] ad_bus,
  input  logic              as_strb,
  input  logic              rd_strb,
  output logic              csel,
  output logic [1:0]        rsel,
  output logic [1:0]        reg_idx,
  output logic              rd_csel
);

  logic              rst_i;
  logic [BYTE_W-1:0] hi_q;
  dec_out_t          dec_w;
  dec_out_t          out_d;
  dec_out_t          out_q;

  mawd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_i (rst_i)
  );

  mawd_hi_latch #(.BYTE_W(BYTE_W)) u_hi (
    .clk   (clk),
    .rst_i (rst_i),
    .load  (as_strb),
    .din   (ad_bus),
    .hi_q  (hi_q)
  );

  mawd_lo_decode #(.BYTE_W(BYTE_W), .IDX_LSB(IDX_LSB)) u_dec (
    .hi_byte (hi_q),
    .lo_byte (ad_bus),
    .rd      (rd_strb),
    .dec     (dec_w)
  );

  always_comb begin
    out_d = dec_w;
    if (as_strb) out_d = DEC_IDLE;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) out_q <= DEC_IDLE;
    else        out_q <= out_d;
  end

  assign csel    = out_q.cs;
  assign rsel    = out_q.rs;
  assign reg_idx = out_q.idx;
  assign rd_csel = out_q.rd_cs;

  AST_TOP_QUARTER_DEAD: assert property (@(posedge clk) disable iff (!rst_i)
    csel |-> (reg_idx != 2'b11)); // R5

  AST_STROBE_IDLES: assert property (@(posedge clk) disable iff (!rst_i)
    as_strb |=> (!csel && !rd_csel && rsel == 2'b11)); // R8

  AST_RD_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_i)
    rd_csel |-> csel); // R9

  AST_CS_NEEDS_PAGE: assert property (@(posedge clk) disable iff (!rst_i)
    csel |-> (&hi_q)); // R10

  AST_IDX_FOLLOWS_RS: assert property (@(posedge clk) disable iff (!rst_i)
    csel |-> (reg_idx == rsel)); // R6

endmodule

// File: tb/mawd_window_dec_test.sv
module mawd_window_dec_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ad_bus = 8'h00;
  logic       as_strb = 1'b0;
  logic       rd_strb = 1'b0;
  logic       csel;
  logic [1:0] rsel;
  logic [1:0] reg_idx;
  logic       rd_csel;

  mawd_window_dec uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .ad_bus  (ad_bus),
    .as_strb (as_strb),
    .rd_strb (rd_strb),
    .csel    (csel),
    .rsel    (rsel),
    .reg_idx (reg_idx),
    .rd_csel (rd_csel)
  );

  always #4 clk = ~clk;

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  string tag = "R1";
  string exp_tag = "R1";

  int m_hi = 0;
  int m_rel = 0;
  int e_cs = 0, e_rs = 3, e_idx = 0, e_rd = 0;

  always @(posedge clk) begin
    int addr;
    exp_tag = tag;
    if (!rst_n) begin
      m_rel = 0; m_hi = 0;
      e_cs = 0; e_rs = 3; e_idx = 0; e_rd = 0;
    end else if (m_rel < 2) begin
      m_rel++; m_hi = 0;
      e_cs = 0; e_rs = 3; e_idx = 0; e_rd = 0;
    end else if (as_strb) begin
      m_hi = ad_bus;
      e_cs = 0; e_rs = 3; e_idx = 0; e_rd = 0;
    end else begin
      addr  = m_hi * 256 + ad_bus;
      e_cs  = (addr >= 'hFFF0 && addr <= 'hFFFB) ? 1 : 0;
      e_rs  = (ad_bus >= 'hF0) ? (ad_bus / 4) % 4 : 3;
      e_idx = e_cs ? (addr - 'hFFF0) / 4 : 0;
      e_rd  = e_cs & rd_strb;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      cyc++;
      n_chk++;
      if (csel !== e_cs[0] || rsel !== e_rs[1:0] ||
          reg_idx !== e_idx[1:0] || rd_csel !== e_rd[0]) begin
        n_fail++;
        $display("FAIL %s cycle %0d: cs/rs/idx/rd actual %b/%0d/%0d/%b expected %0d/%0d/%0d/%0d",
                 exp_tag, cyc, csel, rsel, reg_idx, rd_csel, e_cs, e_rs, e_idx, e_rd);
      end
      if (cyc > 20000) begin
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual running expected finished");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  task automatic bus_cycle(input logic [7:0] hi, input logic [7:0] lo,
                           input logic rd, input string t);
    @(negedge clk);
    tag = t; as_strb = 1'b1; ad_bus = hi; rd_strb = 1'b0;
    @(negedge clk);
    as_strb = 1'b0; ad_bus = lo; rd_strb = rd;
    @(negedge clk);
    ad_bus = 8'h00; rd_strb = 1'b0;
  endtask

  task automatic lo_only(input logic [7:0] lo, input logic rd, input string t);
    @(negedge clk);
    tag = t; as_strb = 1'b0; ad_bus = lo; rd_strb = rd;
  endtask

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    n_chk++;
    if (csel !== 1'b0 || rsel !== 2'b11 || reg_idx !== 2'b00 || rd_csel !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: actual %b/%0d/%0d/%b expected 0/3/0/0", csel, rsel, reg_idx, rd_csel);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 R4 R5 R6: sweep the upper part of the last page
    for (int lo = 'hE0; lo <= 'hFF; lo++)
      bus_cycle(8'hFF, lo[7:0], lo[0], "R3_R4_R5_R6");

    // R4: low nibble rule with other lows
    for (int lo = 0; lo < 256; lo += 17)
      bus_cycle(8'hFF, lo[7:0], 1'b1, "R4");

    // R10: wrong upper byte
    for (int lo = 'hF0; lo <= 'hFB; lo++)
      bus_cycle(8'hFE, lo[7:0], 1'b1, "R10");
    bus_cycle(8'h7F, 8'hF8, 1'b1, "R10");

    // R7: three-byte fetch from the page register
    bus_cycle(8'hFF, 8'hF8, 1'b1, "R7");
    bus_cycle(8'hFF, 8'hF9, 1'b1, "R7");
    bus_cycle(8'hFF, 8'hFA, 1'b1, "R7");

    // R2: upper byte held while low bytes change without a strobe
    bus_cycle(8'hFF, 8'hF0, 1'b0, "R2");
    lo_only(8'hF5, 1'b1, "R2");
    lo_only(8'hF9, 1'b0, "R2");
    lo_only(8'hFC, 1'b1, "R2");
    lo_only(8'hF3, 1'b1, "R2");
    bus_cycle(8'h12, 8'hF3, 1'b1, "R2");
    lo_only(8'hF7, 1'b1, "R2");

    // R8: strobe held high with a valid low byte on the bus
    @(negedge clk);
    tag = "R8"; as_strb = 1'b1; ad_bus = 8'hFF;
    @(negedge clk);
    ad_bus = 8'hF4; rd_strb = 1'b1;
    @(negedge clk);
    ad_bus = 8'hF8;
    @(negedge clk);
    as_strb = 1'b0; ad_bus = 8'hF8;

    // R9: read qualification toggled on a selected address
    lo_only(8'hF0, 1'b0, "R9");
    lo_only(8'hF0, 1'b1, "R9");
    lo_only(8'hFB, 1'b1, "R9");
    lo_only(8'hFB, 1'b0, "R9");

    // R1: reset again mid-traffic
    @(negedge clk);
    tag = "R1"; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    lo_only(8'hF4, 1'b1, "R1");
    lo_only(8'hF4, 1'b1, "R1");
    lo_only(8'hF4, 1'b1, "R1");
    bus_cycle(8'hFF, 8'hF4, 1'b1, "R6");
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule